// File: doc/BRIEF.md
# Prescaled Event Counter

This block pairs a reloading down-counter, the phase counter, with a free-running up-counter, the event counter. Both advance only on cycles where a one-cycle tick enable is high. The tick enable is produced outside the block by dividing the system clock, so the whole block sits in one clock domain. The default tick rate is 20 MHz.

On every tick the phase counter steps down by one. On the tick after it has reached zero, it instead reloads from a programmable reload value, and the event counter advances by one on that same tick. The event counter therefore counts periods of `reload + 1` ticks. With a reload value of zero the phase counter stays at zero, and the event counter then advances on every tick.

Each of the three registers has its own load strobe and data input. Software can write any register at any moment. All three registers are visible on outputs one cycle after the edge that updates them.

Top module: `prescaled_event_counter`

## Requirements
- R1: While `rst_ni` is low, the reload value, the phase counter and the event counter all read zero on the next cycle.
- R2: On a tick with no phase load and a nonzero phase counter, the phase counter drops by one and the event counter is unchanged.
- R3: On a tick where the phase counter is already zero, the phase counter takes the reload value held before that edge, and the event counter rises by one on the same edge.
- R4: With reload 5 and phase 7, fourteen ticks give the phase values 6,5,4,3,2,1,0,5,4,3,2,1,0,5. The event counter rises on the 8th and the 14th tick.
- R5: With reload zero, a phase counter at zero stays at zero and the event counter rises on every tick.
- R6: On a cycle with no tick and no loads, all three outputs hold their values.
- R7: A load strobe places its data in its register on the next edge, whether or not a tick is present. A load on one register does not stop the other registers from following their tick rules in that cycle.
- R8: Loading the reload value does not change the phase counter. The new value is used only from the next reload onward.
- R9: The event counter wraps from all ones to zero and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle prescale tick enable |
| rate_ld_i | input | 1 | Load strobe for the reload value |
| rate_val_i | input | W | Data for the reload value |
| phase_ld_i | input | 1 | Load strobe for the phase counter |
| phase_val_i | input | W | Data for the phase counter |
| evt_ld_i | input | 1 | Load strobe for the event counter |
| evt_val_i | input | W | Data for the event counter |
| rate_o | output | W | Current reload value |
| phase_o | output | W | Current phase counter |
| evt_o | output | W | Current event counter |

## Verification
The assertions are evaluated on every cycle. They cover the one-step decrement, the reload from the previous reload value, the rule that zero stays at zero, the single-step rise of the event counter, its wrap to zero, holding when no tick is present, and loads taking priority. Some behaviour needs the bench's scenarios instead. These are the full 14-tick sequence with its two increment points, the delayed effect of a reload change, load-and-tick collisions spanning both counters, and a run driven by a divided tick.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_DEC    = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_LOAD   = 2'd3
    } phase_act_e;
endpackage

// File: rtl/evc_phase.sv
module evc_phase #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [W-1:0] rate_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] phase_o,
    output logic         wrap_o
);
    import evc_pkg::*;

    typedef struct packed {
        logic [W-1:0] phase;
    } state_t;

    state_t     st_d, st_q;
    phase_act_e act;
    logic       at_zero;

    always_comb begin
        at_zero = (st_q.phase == '0);
        if (ld_i)
            act = ACT_LOAD;
        else if (tick_i && at_zero)
            act = ACT_RELOAD;
        else if (tick_i)
            act = ACT_DEC;
        else
            act = ACT_HOLD;

        st_d = st_q;
        unique case (act)
            ACT_LOAD:   st_d.phase = ld_val_i;
            ACT_RELOAD: st_d.phase = rate_i;
            ACT_DEC:    st_d.phase = st_q.phase - W'(1);
            default:    st_d.phase = st_q.phase;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // the wrap event follows the tick rule even while a load overrides the phase
    assign wrap_o  = tick_i && at_zero;
    assign phase_o = st_q.phase;

    a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !ld_i && phase_o != '0) |=> (phase_o == $past(phase_o) - W'(1)));

    a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !ld_i && phase_o == '0) |=> (phase_o == $past(rate_i)));

    a_r5_stick_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !ld_i && phase_o == '0 && rate_i == '0) |=> (phase_o == '0));

    a_r6_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !ld_i) |=> $stable(phase_o));

    a_r7_phase_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i |=> (phase_o == $past(ld_val_i)));
endmodule

// File: rtl/evc_events.sv
module evc_events #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] count_o
);
    typedef struct packed {
        logic [W-1:0] count;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i)
            st_d.count = ld_val_i;
        else if (inc_i)
            st_d.count = st_q.count + W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count_o = st_q.count;

    a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !ld_i) |=> (count_o == $past(count_o) + W'(1)));

    a_r9_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !ld_i && count_o == '1) |=> (count_o == '0));

    a_r6_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && !ld_i) |=> $stable(count_o));

    a_r7_count_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i |=> (count_o == $past(ld_val_i)));
endmodule

// File: rtl/prescaled_event_counter.sv
module prescaled_event_counter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         rate_ld_i,
    input  logic [W-1:0] rate_val_i,
    input  logic         phase_ld_i,
    input  logic [W-1:0] phase_val_i,
    input  logic         evt_ld_i,
    input  logic [W-1:0] evt_val_i,
    output logic [W-1:0] rate_o,
    output logic [W-1:0] phase_o,
    output logic [W-1:0] evt_o
);
    typedef struct packed {
        logic [W-1:0] rate;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wrap;

    always_comb begin
        cfg_d = cfg_q;
        if (rate_ld_i)
            cfg_d.rate = rate_val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    assign rate_o = cfg_q.rate;

    evc_phase #(.W(W)) phase_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .rate_i   (cfg_q.rate),
        .ld_i     (phase_ld_i),
        .ld_val_i (phase_val_i),
        .phase_o  (phase_o),
        .wrap_o   (wrap)
    );

    evc_events #(.W(W)) events_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .inc_i    (wrap),
        .ld_i     (evt_ld_i),
        .ld_val_i (evt_val_i),
        .count_o  (evt_o)
    );

    a_r8_rate_no_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_ld_i && !tick_i && !phase_ld_i) |=> $stable(phase_o));

    a_r3_wrap_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !evt_ld_i) |=> $stable(evt_o));
endmodule

// File: tb/prescaled_event_counter_tb_top.sv
module prescaled_event_counter_tb_top;
    localparam int W   = 32;
    localparam int DIV = 5; // 100 MHz / 5 = 20 MHz tick
    localparam int unsigned EXP_PH [14] = '{6,5,4,3,2,1,0,5,4,3,2,1,0,5};
    localparam int unsigned EXP_EV [14] = '{0,0,0,0,0,0,0,1,1,1,1,1,1,2};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         r_ld = 1'b0, p_ld = 1'b0, e_ld = 1'b0;
    logic [W-1:0] r_val = '0, p_val = '0, e_val = '0;
    logic [W-1:0] rate_o, phase_o, evt_o;
    int           n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    prescaled_event_counter #(.W(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .rate_ld_i(r_ld), .rate_val_i(r_val),
        .phase_ld_i(p_ld), .phase_val_i(p_val),
        .evt_ld_i(e_ld), .evt_val_i(e_val),
        .rate_o(rate_o), .phase_o(phase_o), .evt_o(evt_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk3(input string tag, input logic [W-1:0] r, input logic [W-1:0] p,
                        input logic [W-1:0] e);
        chk({tag, " rate"}, rate_o, r);
        chk({tag, " phase"}, phase_o, p);
        chk({tag, " events"}, evt_o, e);
    endtask

    // drive at a falling edge, let the rising edge latch, return at the next falling edge
    task automatic step(input logic t, input logic lr, input logic [W-1:0] vr,
                        input logic lp, input logic [W-1:0] vp,
                        input logic le, input logic [W-1:0] ve);
        tick = t; r_ld = lr; r_val = vr; p_ld = lp; p_val = vp; e_ld = le; e_val = ve;
        @(negedge clk);
        tick = 0; r_ld = 0; p_ld = 0; e_ld = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk3("R1 reset", '0, '0, '0);
        rst_n = 1'b1;

        // R7: two loads in one cycle
        step(0, 1, 5, 1, 7, 0, 0);
        chk3("R7 load", 5, 7, 0);

        // R2 R3 R4: vector walk
        for (int i = 0; i < 14; i++) begin
            ticks(1);
            chk($sformatf("R4 phase tick %0d", i + 1), phase_o, EXP_PH[i]);
            chk($sformatf("R4 events tick %0d", i + 1), evt_o, EXP_EV[i]);
        end

        // R6: idle cycles
        repeat (4) step(0, 0, 0, 0, 0, 0, 0);
        chk3("R6 idle", 5, 5, 2);

        // R8: reload change leaves phase alone, used at next reload
        step(0, 1, 2, 0, 0, 0, 0);
        chk3("R8 rate load", 2, 5, 2);
        ticks(5);
        chk3("R8 run to zero", 2, 0, 2);
        ticks(1);
        chk3("R8 new reload", 2, 2, 3);

        // R7: phase load with tick wins over decrement
        step(1, 0, 0, 1, 9, 0, 0);
        chk3("R7 phase load on tick", 2, 9, 3);
        // R7: event load with wrap tick, phase still reloads
        step(0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 1, 100);
        chk3("R7 event load on wrap", 2, 2, 100);
        // R3: reload uses the value held before the edge
        step(0, 0, 0, 1, 0, 0, 0);
        step(1, 1, 7, 0, 0, 0, 0);
        chk3("R3 old reload", 7, 2, 101);

        // R5: zero reload sticks
        step(0, 1, 0, 1, 0, 1, 10);
        for (int i = 1; i <= 3; i++) begin
            ticks(1);
            chk3($sformatf("R5 zero reload tick %0d", i), 0, 0, 10 + i);
        end
        step(0, 0, 0, 1, 2, 0, 0);
        ticks(2);
        chk3("R5 count down to zero", 0, 0, 13);
        ticks(1);
        chk3("R5 zero tick counts", 0, 0, 14);

        // R9: wrap to zero
        step(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        ticks(1);
        chk3("R9 wrap", 0, 0, 0);

        // R3: divided tick stream, 8 ticks over 40 cycles
        step(0, 1, 3, 1, 0, 1, 0);
        for (int c = 0; c < 8 * DIV; c++)
            step((c % DIV) == 0, 0, 0, 0, 0, 0, 0);
        chk3("R3 divided run", 3, 0, 2);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk3("R1 mid reset", '0, '0, '0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule